// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register storage of a five-stage processor whose register file is divided into overlapping windows. It holds 8 global registers plus NWIN windows of 16 registers each, which is 520 physical entries by default. A separate window-pointer register selects the active window. The pointer is part of the block, and software never addresses it as a general register.

Every 5-bit architectural register number is translated to a physical index. Numbers 0–7 select the shared globals. Numbers 8–15 (outgoing) and 16–23 (local) select the 16 private registers of the active window. Numbers 24–31 (incoming) select the outgoing group of the next-higher window, modulo NWIN. Two adjacent windows therefore share 8 registers. A "save" step moves the pointer down by one and a "restore" step moves it up by one, both with wraparound. In the register-passing convention, the caller's outgoing registers then appear as the callee's incoming registers.

The decode stage uses two combinational read ports. The write-back stage uses one write port, which is registered on the rising clock edge. The window-step command is a 2-bit input: `00` hold, `01` save, `10` restore, `11` reserved (treated as hold).

Top module: `wrf_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cwp` is 0 and every register reads as zero.
- R2: Architectural register 0 always reads as zero on both ports, and a write to it is discarded.
- R3: Registers 1–7 refer to the same physical registers in every window.
- R4: Registers 8–23 are private to a window: writing them in one window leaves those numbers unchanged in any other window.
- R5: Register 24+k in window w is the same physical register as register 8+k in window (w+1) mod NWIN, for k in 0..7.
- R6: `win_op` = `01` (save) sets `cwp` to `cwp`−1 at the next edge, and 0 becomes NWIN−1.
- R7: `win_op` = `10` (restore) sets `cwp` to `cwp`+1 at the next edge, and NWIN−1 becomes 0.
- R8: `win_op` = `00` or `11` leaves `cwp` unchanged.
- R9: When a read port addresses the register that is being written in the same cycle, the port returns `wr_data`. Otherwise it returns the stored value.
- R10: A write in the same cycle as a save or restore is stored in the window selected before the pointer changes.
- R11: The two read ports translate and return values independently of each other within one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_op | input | 2 | Window step: 00 hold, 01 save, 10 restore, 11 hold |
| rs1_addr | input | 5 | Architectural number, read port A |
| rs1_data | output | XLEN | Read data, port A |
| rs2_addr | input | 5 | Architectural number, read port B |
| rs2_data | output | XLEN | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number to write |
| wr_data | input | XLEN | Write data |
| cwp | output | $clog2(NWIN) | Current window pointer |

## Verification
A write-back and a window step can occur in the same cycle. In that case the write must be stored under the old pointer, while reads in that cycle still see the old window with the new value bypassed in. The bench provokes this by issuing a save together with a write to a local register. It then reads that register after a restore, and reads another window's locals to confirm they are still zero. A second collision is a read of the register that is being written in the same cycle. That read is checked on both ports against the incoming data, before the clock edge commits the write.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    // Architectural numbers are 5 bits, split into four groups of 8.
    localparam int ARCH_W   = 5;
    localparam int GRP_SZ   = 8;
    localparam int N_GLOBAL = GRP_SZ;
    localparam int WIN_REGS = 2 * GRP_SZ;

    typedef enum logic [1:0] {
        WOP_HOLD    = 2'b00,
        WOP_SAVE    = 2'b01,
        WOP_RESTORE = 2'b10,
        WOP_RSVD    = 2'b11
    } win_op_e;
endpackage

// File: rtl/wrf_index_map.sv
module wrf_index_map
    import wrf_pkg::*;
#(
    parameter int NWIN   = 32,
    parameter int WIN_W  = $clog2(NWIN),
    parameter int PIDX_W = $clog2(N_GLOBAL + NWIN * WIN_REGS)
) (
    input  logic [ARCH_W-1:0] arch,
    input  logic [WIN_W-1:0]  cur_win,
    output logic [PIDX_W-1:0] phys
);
    int unsigned a_num;
    int unsigned w_sel;
    int unsigned offs;

    always_comb begin
        a_num = int'(arch);
        w_sel = int'(cur_win);
        offs  = 0;
        if (a_num < GRP_SZ) begin
            phys = PIDX_W'(a_num);
        end else begin
            if (a_num >= 3 * GRP_SZ) begin
                // incoming group aliases the next window's outgoing group
                w_sel = (int'(cur_win) == NWIN - 1) ? 0 : int'(cur_win) + 1;
                offs  = a_num - 3 * GRP_SZ;
            end else begin
                offs  = a_num - GRP_SZ;
            end
            phys = PIDX_W'(N_GLOBAL + w_sel * WIN_REGS + offs);
        end
    end
endmodule

// File: rtl/wrf_winptr.sv
module wrf_winptr
    import wrf_pkg::*;
#(
    parameter int NWIN  = 32,
    parameter int WIN_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  win_op_e          op,
    output logic [WIN_W-1:0] cur_win
);
    localparam logic [WIN_W-1:0] TOP_WIN = WIN_W'(NWIN - 1);

    logic [WIN_W-1:0] nxt_win;

    always_comb begin
        unique case (op)
            WOP_SAVE:    nxt_win = (cur_win == '0) ? TOP_WIN : cur_win - 1'b1;
            WOP_RESTORE: nxt_win = (cur_win == TOP_WIN) ? '0 : cur_win + 1'b1;
            WOP_HOLD,
            WOP_RSVD:    nxt_win = cur_win;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_win <= '0;
        else        cur_win <= nxt_win;
    end
endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
    parameter int DEPTH  = 520,
    parameter int XLEN   = 32,
    parameter int NRD    = 2,
    parameter int PIDX_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [PIDX_W-1:0]          widx,
    input  logic [XLEN-1:0]            wdata,
    input  logic [NRD-1:0][PIDX_W-1:0] ridx,
    output logic [NRD-1:0][XLEN-1:0]   rdata
);
    logic [XLEN-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[widx] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cells[ridx[p]];
    end
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile
    import wrf_pkg::*;
#(
    parameter int NWIN  = 32,
    parameter int XLEN  = 32,
    parameter int WIN_W = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        win_op,
    input  logic [ARCH_W-1:0] rs1_addr,
    output logic [XLEN-1:0]   rs1_data,
    input  logic [ARCH_W-1:0] rs2_addr,
    output logic [XLEN-1:0]   rs2_data,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_addr,
    input  logic [XLEN-1:0]   wr_data,
    output logic [WIN_W-1:0]  cwp
);
    localparam int NRD    = 2;
    localparam int DEPTH  = N_GLOBAL + NWIN * WIN_REGS;
    localparam int PIDX_W = $clog2(DEPTH);

    logic [NRD-1:0][ARCH_W-1:0] rd_arch;
    logic [NRD-1:0][PIDX_W-1:0] rd_phys;
    logic [NRD-1:0][XLEN-1:0]   rd_cell;
    logic [NRD-1:0][XLEN-1:0]   rd_out;
    logic [PIDX_W-1:0]          wr_phys;
    logic                       wr_live;

    assign rd_arch[0] = rs1_addr;
    assign rd_arch[1] = rs2_addr;
    assign wr_live    = wr_en && (wr_addr != '0);

    wrf_winptr #(.NWIN(NWIN), .WIN_W(WIN_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .op(win_op_e'(win_op)), .cur_win(cwp)
    );

    wrf_index_map #(.NWIN(NWIN), .WIN_W(WIN_W), .PIDX_W(PIDX_W)) u_wmap (
        .arch(wr_addr), .cur_win(cwp), .phys(wr_phys)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        wrf_index_map #(.NWIN(NWIN), .WIN_W(WIN_W), .PIDX_W(PIDX_W)) u_rmap (
            .arch(rd_arch[p]), .cur_win(cwp), .phys(rd_phys[p])
        );
        always_comb begin
            if (rd_arch[p] == '0)                     rd_out[p] = '0;
            else if (wr_live && rd_phys[p] == wr_phys) rd_out[p] = wr_data;
            else                                       rd_out[p] = rd_cell[p];
        end
    end

    wrf_bank #(.DEPTH(DEPTH), .XLEN(XLEN), .NRD(NRD), .PIDX_W(PIDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_live), .widx(wr_phys), .wdata(wr_data),
        .ridx(rd_phys), .rdata(rd_cell)
    );

    assign rs1_data = rd_out[0];
    assign rs2_data = rd_out[1];
endmodule

// File: rtl/wrf_regfile_chk.sv
module wrf_regfile_chk #(
    parameter int NWIN  = 32,
    parameter int XLEN  = 32,
    parameter int WIN_W = $clog2(NWIN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       win_op,
    input logic [4:0]       rs1_addr,
    input logic [XLEN-1:0]  rs1_data,
    input logic [4:0]       rs2_addr,
    input logic [XLEN-1:0]  rs2_data,
    input logic             wr_en,
    input logic [4:0]       wr_addr,
    input logic [XLEN-1:0]  wr_data,
    input logic [WIN_W-1:0] cwp
);
    localparam logic [WIN_W-1:0] TOPW = WIN_W'(NWIN - 1);

    // R2
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_addr == 5'd0) |-> (rs1_data == '0));
    // R2
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs2_addr == 5'd0) |-> (rs2_data == '0));
    // R6
    save_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == 2'b01) |=> (cwp == (($past(cwp) == '0) ? TOPW : $past(cwp) - 1'b1)));
    // R7
    restore_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == 2'b10) |=> (cwp == (($past(cwp) == TOPW) ? '0 : $past(cwp) + 1'b1)));
    // R8
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_op == 2'b00 || win_op == 2'b11) |=> $stable(cwp));
    // R9
    bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 5'd0 && rs1_addr == wr_addr) |-> (rs1_data == wr_data));
    // R9
    bypass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 5'd0 && rs2_addr == wr_addr) |-> (rs2_data == wr_data));
    // R1
    reset_ptr_chk: assert property (@(posedge clk) !rst_n |-> (cwp == '0));
endmodule

bind wrf_regfile wrf_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN), .WIN_W(WIN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .win_op(win_op), .rs1_addr(rs1_addr), .rs1_data(rs1_data),
    .rs2_addr(rs2_addr), .rs2_data(rs2_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cwp(cwp)
);

// File: tb/wrf_regfile_tb_top.sv
module wrf_regfile_tb_top;
    localparam int NWIN = 32;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      win_op = 2'b00;
    logic [4:0]      rs1_addr = '0, rs2_addr = '0, wr_addr = '0;
    logic [XLEN-1:0] rs1_data, rs2_data, wr_data = '0;
    logic            wr_en = 1'b0;
    logic [4:0]      cwp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wrf_regfile #(.NWIN(NWIN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .win_op(win_op), .rs1_addr(rs1_addr), .rs1_data(rs1_data),
        .rs2_addr(rs2_addr), .rs2_data(rs2_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cwp(cwp)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        we;
        logic [4:0]  wa;
        logic [31:0] wd;
        logic [4:0]  ra1;
        logic [4:0]  ra2;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [4:0]  ecwp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R9 R2: global write bypassed, r0 zero
        '{2'b00, 1'b1, 5'd1,  32'h11, 5'd1,  5'd0,  32'h11, 32'h0,  5'd0,  8'd9},
        // R9 R11: bypass on port B, port A reads stored global
        '{2'b00, 1'b1, 5'd8,  32'hA8, 5'd1,  5'd8,  32'h11, 32'hA8, 5'd0,  8'd11},
        // R10: save together with a local write, old window visible
        '{2'b01, 1'b1, 5'd16, 32'hB0, 5'd8,  5'd16, 32'hA8, 32'hB0, 5'd0,  8'd10},
        // R6 R5 R4: window 31, ins alias window 0 outs, locals private
        '{2'b00, 1'b0, 5'd0,  32'h0,  5'd24, 5'd16, 32'hA8, 32'h0,  5'd31, 8'd5},
        // R3: global shared, outs of window 31 empty
        '{2'b00, 1'b1, 5'd8,  32'hC8, 5'd1,  5'd15, 32'h11, 32'h0,  5'd31, 8'd3},
        // R7: restore from 31, read own outs and ins
        '{2'b10, 1'b0, 5'd0,  32'h0,  5'd8,  5'd24, 32'hC8, 32'hA8, 5'd31, 8'd7},
        // R10 R4: back in window 0, saved local present; reserved op
        '{2'b11, 1'b0, 5'd0,  32'h0,  5'd8,  5'd16, 32'hA8, 32'hB0, 5'd0,  8'd4},
        // R8 R2: reserved op held; write to r0 discarded; ins of window 0 empty
        '{2'b10, 1'b1, 5'd0,  32'hFF, 5'd0,  5'd24, 32'h0,  32'h0,  5'd0,  8'd8},
        // R7 R2: window 1, r0 stays zero after attempted write
        '{2'b00, 1'b0, 5'd0,  32'h0,  5'd0,  5'd1,  32'h0,  32'h11, 5'd1,  8'd2},
        // R4: window 1 locals unaffected
        '{2'b00, 1'b0, 5'd0,  32'h0,  5'd16, 5'd8,  32'h0,  32'h0,  5'd1,  8'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        win_op = 2'b00; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk); rs1_addr = 5'd9; rs2_addr = 5'd31; #1;
        chk("R1 cwp in reset", 32'(cwp), 32'd0);
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 cwp after reset", 32'(cwp), 32'd0);
        chk("R1 rs1 zero", rs1_data, 32'h0);
        chk("R1 rs2 zero", rs2_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            win_op = TBL[i].op; wr_en = TBL[i].we; wr_addr = TBL[i].wa; wr_data = TBL[i].wd;
            rs1_addr = TBL[i].ra1; rs2_addr = TBL[i].ra2;
            #1;
            chk($sformatf("R%0d step %0d cwp", TBL[i].rq, i), 32'(cwp), 32'(TBL[i].ecwp));
            chk($sformatf("R%0d step %0d rs1", TBL[i].rq, i), rs1_data, TBL[i].e1);
            chk($sformatf("R%0d step %0d rs2", TBL[i].rq, i), rs2_data, TBL[i].e2);
        end
        @(negedge clk); idle();

        // R6: NWIN saves walk the pointer around once, wrapping at 0
        for (int i = 0; i < NWIN; i++) begin
            @(negedge clk); win_op = 2'b01;
            #1 chk("R6 save walk", 32'(cwp), 32'((1 - i + 2 * NWIN) % NWIN));
        end
        @(negedge clk); idle(); #1;
        chk("R6 full circle", 32'(cwp), 32'd1);

        // R5: write outs of window 1, restore-side view: save to window 0, read ins
        wr_en = 1'b1; wr_addr = 5'd13; wr_data = 32'h5D;
        @(negedge clk); idle(); win_op = 2'b01;
        @(negedge clk); idle(); rs1_addr = 5'd29; rs2_addr = 5'd13; #1;
        chk("R5 ins alias", rs1_data, 32'h5D);
        chk("R5 own outs", rs2_data, 32'h0);

        // R1: reset in the middle clears state
        @(negedge clk); win_op = 2'b10;
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; rs1_addr = 5'd1; rs2_addr = 5'd16; #1;
        chk("R1 midrun cwp", 32'(cwp), 32'd0);
        chk("R1 midrun global", rs1_data, 32'h0);
        chk("R1 midrun local", rs2_data, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule